// File: doc/BRIEF.md
# Inverted Page Table Search Unit

This block translates a virtual page number into a physical address using a table with one slot per physical frame. Each slot records which virtual page currently lives in that frame, together with a per-slot valid flag. The table stores only resident mappings, so its size follows the physical memory and not the virtual address space. The cost is that a lookup cannot index the table. The unit searches it instead, and the slot position where the search stops is the physical frame number.

A request carries a 20-bit virtual page number and a 12-bit page offset. Once the unit accepts a request, it examines one slot per clock, starting at slot 0, and stops at the first valid slot holding the requested page. It then returns the physical address formed from that slot index and the original offset. If every slot is examined without a match, the unit returns a fault. Software fills or clears slots through a one-cycle write port.

Top module: `ipt_search_unit`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and every slot is invalid, so any request made before a write returns a fault.
- R2: On a hit at slot k, resp_paddr is the slot index zero-extended to a 20-bit physical page, placed above the unchanged 12-bit offset. For example, a request for page 0x00001 with offset 0x144, held in slot 0xFE, gives 0x000FE144.
- R3: The search starts at slot 0 and moves upward. When several valid slots hold the requested page, the lowest-numbered one is reported.
- R4: A hit at slot k raises resp_valid k+1 clock edges after the edge that accepted the request. A fault raises it 256 edges after that edge (FRAMES = 256).
- R5: When no valid slot matches, resp_valid comes with resp_fault = 1 and resp_paddr = 0. On a hit, resp_fault is 0.
- R6: A write with wr_set = 0 invalidates a slot. A slot marked invalid never matches, even if its stored page equals the request.
- R7: req_ready is 0 from acceptance until the response. req_valid raised during that time does not change the response in flight and does not start a new search.
- R8: resp_valid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| req_off | input | 12 | Page offset |
| wr_en | input | 1 | Slot write strobe |
| wr_frame | input | 8 | Slot (physical frame) to write |
| wr_vpn | input | 20 | Virtual page stored in the slot |
| wr_set | input | 1 | 1 marks the slot valid, 0 invalid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | No mapping found |
| resp_paddr | output | 32 | Physical address; 0 on fault |

## Verification
Each result has a fixed due time. A hit at slot k is due k+1 edges after the accepting edge, and a fault is due 256 edges after it. The bench counts falling edges from that accepting edge and reports an error if resp_valid arrives early, arrives late, or appears in the cycle after it was due. The cases cover slot 0, slot 255 and a full miss, so every possible latency bound is exercised. During a search the bench raises req_valid repeatedly, then checks that req_ready stays high and no second response appears.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    parameter int VPN_W   = 20;
    parameter int OFF_W   = 12;
    parameter int FRAMES  = 256;
    localparam int FRAME_W = $clog2(FRAMES);
    localparam int PA_W    = VPN_W + OFF_W;

    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [PA_W-1:0]    paddr_t;

    typedef struct packed {
        vpn_t vpn;
        off_t off;
    } vaddr_s;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } scan_state_e;

    function automatic paddr_t make_paddr(frame_t fr, off_t off);
        vpn_t ppn;
        ppn = '0;
        ppn[FRAME_W-1:0] = fr;
        return {ppn, off};
    endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table
    import ipt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  frame_t wr_frame,
    input  vpn_t   wr_vpn,
    input  logic   wr_set,
    input  frame_t rd_idx,
    output vpn_t   rd_vpn,
    output logic   rd_valid
);

    vpn_t              slot_vpn [FRAMES];
    logic [FRAMES-1:0] slot_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
        end else if (wr_en) begin
            slot_vld[wr_frame] <= wr_set;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_vpn[wr_frame] <= wr_vpn;
        end
    end

    assign rd_vpn   = slot_vpn[rd_idx];
    assign rd_valid = slot_vld[rd_idx];

    // R6: a written slot reads back with the requested validity
    a_r6_write_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_frame == rd_idx) |=> ($past(rd_idx) != rd_idx) || (rd_valid == $past(wr_set)) || wr_en);

endmodule

// File: rtl/ipt_match.sv
module ipt_match
    import ipt_pkg::*;
(
    input  vpn_t   key,
    input  vpn_t   slot_vpn,
    input  logic   slot_valid,
    input  frame_t idx,
    output logic   hit,
    output logic   last
);

    localparam frame_t LAST_IDX = frame_t'(FRAMES - 1);

    always_comb begin
        hit  = slot_valid && (slot_vpn == key);
        last = (idx == LAST_IDX);
    end

endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl
    import ipt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  vpn_t   req_vpn,
    input  off_t   req_off,
    output logic   req_ready,
    output vpn_t   key,
    output frame_t idx,
    input  logic   hit,
    input  logic   last,
    input  vpn_t   slot_vpn,
    input  logic   slot_valid,
    output logic   resp_valid,
    output logic   resp_fault,
    output paddr_t resp_paddr
);

    scan_state_e state_q;
    vaddr_s      cur_q;
    frame_t      idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            idx_q      <= '0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_q   <= '{vpn: req_vpn, off: req_off};
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (hit) begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b0;
                        resp_paddr <= make_paddr(idx_q, cur_q.off);
                        state_q    <= ST_IDLE;
                    end else if (last) begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b1;
                        resp_paddr <= '0;
                        state_q    <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign key       = cur_q.vpn;
    assign idx       = idx_q;

    // R7: accepting a request makes the unit busy
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8: response strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R2: a hit response comes from a valid slot holding the searched page
    a_r2_hit_from_slot: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |->
            ($past(slot_valid) && $past(slot_vpn) == $past(cur_q.vpn)
             && resp_paddr[OFF_W +: FRAME_W] == $past(idx_q)));

endmodule

// File: rtl/ipt_search_unit.sv
module ipt_search_unit
    import ipt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic               wr_set,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [PA_W-1:0]    resp_paddr
);

    vpn_t   key;
    frame_t idx;
    vpn_t   slot_vpn;
    logic   slot_valid;
    logic   hit;
    logic   last;

    ipt_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .wr_vpn   (wr_vpn),
        .wr_set   (wr_set),
        .rd_idx   (idx),
        .rd_vpn   (slot_vpn),
        .rd_valid (slot_valid)
    );

    ipt_match u_match (
        .key        (key),
        .slot_vpn   (slot_vpn),
        .slot_valid (slot_valid),
        .idx        (idx),
        .hit        (hit),
        .last       (last)
    );

    ipt_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vpn    (req_vpn),
        .req_off    (req_off),
        .req_ready  (req_ready),
        .key        (key),
        .idx        (idx),
        .hit        (hit),
        .last       (last),
        .slot_vpn   (slot_vpn),
        .slot_valid (slot_valid),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_paddr (resp_paddr)
    );

    // R5: a fault carries no address
    a_r5_fault_zero: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

endmodule

// File: tb/ipt_search_unit_test.sv
module ipt_search_unit_test;

    localparam int CLK_P = 10;
    localparam int NFR   = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [19:0] req_vpn;
    logic [11:0] req_off;
    logic        wr_en;
    logic [7:0]  wr_frame;
    logic [19:0] wr_vpn;
    logic        wr_set;
    logic        resp_valid;
    logic        resp_fault;
    logic [31:0] resp_paddr;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    ipt_search_unit uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vpn    (req_vpn),
        .req_off    (req_off),
        .wr_en      (wr_en),
        .wr_frame   (wr_frame),
        .wr_vpn     (wr_vpn),
        .wr_set     (wr_set),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_paddr (resp_paddr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_slot(input logic [7:0] fr, input logic [19:0] vpn, input logic set);
        @(negedge clk);
        wr_en = 1'b1; wr_frame = fr; wr_vpn = vpn; wr_set = set;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one request and check latency, fault, address and pulse width.
    task automatic do_req(input logic [19:0] vpn, input logic [11:0] off,
                          input bit exp_fault, input logic [31:0] exp_pa,
                          input int exp_lat, input string tag);
        int lat;
        @(negedge clk);
        check(req_ready == 1'b1, {tag, " R7 ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_vpn = vpn; req_off = off;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < NFR + 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " R4 latency"}, lat, exp_lat);
        check(resp_fault == exp_fault, {tag, " R5 fault flag"}, resp_fault, exp_fault);
        check(resp_paddr == exp_pa, {tag, " R2 address"}, resp_paddr, exp_pa);
        @(negedge clk);
        check(resp_valid == 1'b0, {tag, " R8 one-cycle strobe"}, resp_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(resp_valid == 1'b0, "R1 reset resp_valid", resp_valid, 0);
        do_req(20'h00001, 12'h144, 1'b1, 32'h0, NFR, "R1 empty table");
    endtask

    task automatic t_basic_hit();
        write_slot(8'hFE, 20'h00001, 1'b1);
        do_req(20'h00001, 12'h144, 1'b0, 32'h000FE144, 8'hFE + 1, "R2 slot 0xFE");
    endtask

    task automatic t_edges();
        write_slot(8'h00, 20'hABCDE, 1'b1);
        do_req(20'hABCDE, 12'hFFF, 1'b0, 32'h00000FFF, 1, "R4 slot 0");
        write_slot(8'hFF, 20'h55555, 1'b1);
        do_req(20'h55555, 12'h000, 1'b0, 32'h000FF000, NFR, "R4 slot 255");
        do_req(20'h77777, 12'h3A5, 1'b1, 32'h0, NFR, "R5 miss");
    endtask

    task automatic t_order();
        write_slot(8'd9, 20'h12345, 1'b1);
        write_slot(8'd5, 20'h12345, 1'b1);
        do_req(20'h12345, 12'h0AB, 1'b0, 32'h000050AB, 6, "R3 lowest slot");
    endtask

    task automatic t_invalidate();
        write_slot(8'd5, 20'h12345, 1'b0);
        do_req(20'h12345, 12'h0AB, 1'b0, 32'h000090AB, 10, "R6 skip invalid");
        write_slot(8'd9, 20'h12345, 1'b0);
        do_req(20'h12345, 12'h0AB, 1'b1, 32'h0, NFR, "R6 all invalid");
    endtask

    task automatic t_busy();
        int lat;
        write_slot(8'd20, 20'hCAFE0, 1'b1);
        write_slot(8'd3, 20'hBEEF0, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = 20'hCAFE0; req_off = 12'h010;
        @(negedge clk);
        lat = 0;
        req_vpn = 20'hBEEF0; req_off = 12'h020;
        for (int i = 0; i < 10; i++) begin
            check(req_ready == 1'b0, "R7 busy not ready", req_ready, 0);
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        while (!resp_valid && lat < NFR + 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 21, "R7 R4 latency under intrusion", lat, 21);
        check(resp_paddr == 32'h00014010, "R7 in-flight address", resp_paddr, 32'h00014010);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(resp_valid == 1'b0, "R7 no second response", resp_valid, 0);
            check(req_ready == 1'b1, "R7 no second search", req_ready, 1);
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_off = '0;
        wr_en = 1'b0; wr_frame = '0; wr_vpn = '0; wr_set = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_hit();
        t_edges();
        t_order();
        t_invalidate();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule